// File: doc/BRIEF.md
# Ring-Paired Five-Lane Redundant Multiply-Add Voter

This block computes a multiply-add result five times in parallel, once in each of five redundant lanes, and selects one result by comparing neighbouring lanes around a ring. Each lane forms the product of two operands and adds a fault-injection term. That term is a caller-supplied saboteur word masked down to one bit that belongs to that lane only. An inject-enable input turns the saboteur off, and the lanes then agree.

Only lanes that are currently enabled take part in the vote. The first neighbouring pair that both agrees and is fully enabled supplies the output, and a two-digit diagnosis code names that pair. Three of the five lanes are enabled at any time. The enable pattern shifts one lane around the ring whenever the diagnosis changes from the previous output, so the set of lanes that takes part moves after each disturbance. A valid strobe travels with the data, and the result appears two clock cycles after the operands.

Top module: `ringvote_top`

## Requirements
- R1: Lane k (k = 1..5) computes (opA * opB + (sabWord AND 2^(5-k))) modulo 2^32 while injectEn is 1. Lane 1 therefore sees saboteur bit 4, lane 2 bit 3, lane 3 bit 2, lane 4 bit 1 and lane 5 bit 0.
- R2: Pairs are tried in the fixed order (1,2), (2,3), (3,4), (4,5), (5,1). A pair qualifies only when both of its lanes are enabled and their results are equal. The first qualifying pair wins, and its first-named lane supplies outResult.
- R3: outCode holds the first digit of the winning pair in bits [5:3] and the second digit in bits [2:0], so the codes are 12, 23, 34, 45 and 51.
- R4: When no pair qualifies, outResult is lane 5's result and outCode is 55 ({3'd5,3'd5}).
- R5: After each valid output whose code differs from the code of the previous valid output, the enable pattern rotates one place up the ring (lane 1 to lane 2, and so on, with lane 5 wrapping to lane 1). That pattern applies from the next sample on. It never rotates at any other time.
- R6: After reset, lanes 1, 2 and 3 are enabled, lanes 4 and 5 are disabled, the remembered previous code is 55 and outValid is 0.
- R7: While injectEn is 0, every lane yields opA * opB modulo 2^32, and outResult equals that value.
- R8: outValid equals inValid delayed by exactly two clock cycles. A sample with inValid low produces no output and does not rotate the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample on the operand inputs is valid |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| sabWord | input | 16 | Saboteur word; lane k uses bit 5-k |
| injectEn | input | 1 | 1 lets the saboteur term reach the lanes |
| outValid | output | 1 | outResult and outCode are valid |
| outResult | output | 32 | Voted result |
| outCode | output | 6 | Diagnosis: winning pair digits, or 55 |

## Verification
The bench builds the block with its defaults: 16-bit operands, a 32-bit result and five lanes. Because the saboteur reaches only bits 4 down to 0, random saboteur words drawn through random five-bit patterns produce every mix of agreeing and disagreeing lanes. Those mixes drive every ring pair, the all-disagree code and repeated rotations of the enable pattern. Long runs of random valid gaps check that idle samples leave the rotation state untouched.

// File: rtl/ringvote_pkg.sv
package ringvote_pkg;
  localparam int COPIES = 5;
  localparam int DIGW   = 3;
  localparam int CODEW  = 2 * DIGW;

  typedef logic [CODEW-1:0] code_t;

  // control -> datapath
  typedef struct packed {
    logic [COPIES-1:0] enables;
  } ctrl_t;

  // datapath -> control
  typedef struct packed {
    logic  fire;
    code_t code;
  } stat_t;

  function automatic code_t mkCode(input int hi, input int lo);
    logic [DIGW-1:0] h;
    logic [DIGW-1:0] l;
    h = DIGW'(hi);
    l = DIGW'(lo);
    return {h, l};
  endfunction
endpackage

// File: rtl/ringvote_lane.sv
module ringvote_lane #(
  parameter int OPW  = 16,
  parameter int RESW = 32,
  parameter int BITPOS = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  input  logic [OPW-1:0]  sabGated,
  output logic [RESW-1:0] laneRes
);
  localparam int PRODW = 2 * OPW;
  localparam logic [OPW-1:0] LANE_MASK = OPW'(1) << BITPOS;

  logic [PRODW-1:0] prod;
  logic [OPW-1:0]   faultTerm;

  assign prod      = opA * opB;
  assign faultTerm = sabGated & LANE_MASK;

  always_ff @(posedge clk) begin
    if (rst) laneRes <= '0;
    else if (load) laneRes <= RESW'(prod) + RESW'(faultTerm);
  end
endmodule

// File: rtl/ringvote_datapath.sv
module ringvote_datapath
  import ringvote_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int RESW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  input  logic [OPW-1:0]  sabWord,
  input  logic            injectEn,
  input  ctrl_t           ctrlIn,
  output stat_t           statOut,
  output logic            outValid,
  output logic [RESW-1:0] outResult,
  output code_t           outCode
);
  logic [OPW-1:0]  sabGated;
  logic [RESW-1:0] laneRes [COPIES];
  logic            s1Valid;
  logic [RESW-1:0] voteRes;
  code_t           voteCode;

  assign sabGated = injectEn ? sabWord : '0;

  genvar k;
  generate
    for (k = 0; k < COPIES; k++) begin : g_lane
      ringvote_lane #(
        .OPW(OPW), .RESW(RESW), .BITPOS(COPIES - 1 - k)
      ) u_lane (
        .clk(clk), .rst(rst), .load(inValid),
        .opA(opA), .opB(opB), .sabGated(sabGated),
        .laneRes(laneRes[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) s1Valid <= 1'b0;
    else     s1Valid <= inValid;
  end

  // ring voter: first enabled agreeing neighbour pair wins
  always_comb begin
    logic found;
    found    = 1'b0;
    voteRes  = laneRes[COPIES-1];
    voteCode = mkCode(COPIES, COPIES);
    for (int p = 0; p < COPIES; p++) begin
      if (!found && ctrlIn.enables[p] && ctrlIn.enables[(p + 1) % COPIES] &&
          (laneRes[p] == laneRes[(p + 1) % COPIES])) begin
        found    = 1'b1;
        voteRes  = laneRes[p];
        voteCode = mkCode(p + 1, ((p + 1) % COPIES) + 1);
      end
    end
  end

  assign statOut.fire = s1Valid;
  assign statOut.code = voteCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outResult <= '0;
      outCode   <= mkCode(COPIES, COPIES);
    end else begin
      outValid <= s1Valid;
      if (s1Valid) begin
        outResult <= voteRes;
        outCode   <= voteCode;
      end
    end
  end
endmodule

// File: rtl/ringvote_control.sv
module ringvote_control
  import ringvote_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  stat_t statIn,
  output ctrl_t ctrlOut
);
  localparam logic [COPIES-1:0] RESET_EN = COPIES'(7);

  logic [COPIES-1:0] enReg;
  code_t             prevCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg    <= RESET_EN;
      prevCode <= mkCode(COPIES, COPIES);
    end else if (statIn.fire) begin
      if (statIn.code != prevCode)
        enReg <= {enReg[COPIES-2:0], enReg[COPIES-1]};
      prevCode <= statIn.code;
    end
  end

  assign ctrlOut.enables = enReg;
endmodule

// File: rtl/ringvote_top.sv
module ringvote_top
  import ringvote_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int RESW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  input  logic [OPW-1:0]  sabWord,
  input  logic            injectEn,
  output logic            outValid,
  output logic [RESW-1:0] outResult,
  output logic [CODEW-1:0] outCode
);
  ctrl_t ctrlBus;
  stat_t statBus;

  ringvote_datapath #(.OPW(OPW), .RESW(RESW)) u_dp (
    .clk(clk), .rst(rst), .inValid(inValid),
    .opA(opA), .opB(opB), .sabWord(sabWord), .injectEn(injectEn),
    .ctrlIn(ctrlBus), .statOut(statBus),
    .outValid(outValid), .outResult(outResult), .outCode(outCode)
  );

  ringvote_control u_ctl (
    .clk(clk), .rst(rst), .statIn(statBus), .ctrlOut(ctrlBus)
  );
endmodule

// File: rtl/ringvote_checker.sv
module ringvote_checker
  import ringvote_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              outValid,
  input logic [CODEW-1:0]  outCode,
  input logic [COPIES-1:0] enVec
);
  logic [COPIES-1:0] enPrev;
  logic [DIGW-1:0]   hiDig;
  logic [DIGW-1:0]   loDig;
  logic              hiOn;
  logic              loOn;
  logic              codeLegal;

  always_ff @(posedge clk) enPrev <= enVec;

  assign hiDig = outCode[CODEW-1:DIGW];
  assign loDig = outCode[DIGW-1:0];

  always_comb begin
    hiOn = 1'b0;
    loOn = 1'b0;
    codeLegal = (outCode == mkCode(COPIES, COPIES));
    for (int d = 1; d <= COPIES; d++) begin
      if (int'(hiDig) == d) hiOn = enPrev[d-1];
      if (int'(loDig) == d) loOn = enPrev[d-1];
      if (int'(hiDig) == d && int'(loDig) == (d % COPIES) + 1) codeLegal = 1'b1;
    end
  end

  // R8: two-cycle valid latency
  a_r8_valid_latency: assert property (@(posedge clk) disable iff (rst)
    outValid == $past(inValid, 2));

  // R3: only ring-neighbour codes or 55
  a_r3_code_legal: assert property (@(posedge clk) disable iff (rst)
    outValid |-> codeLegal);

  // R2: a winning pair was fully enabled when voted
  a_r2_pair_enabled: assert property (@(posedge clk) disable iff (rst)
    (outValid && outCode != mkCode(COPIES, COPIES)) |-> (hiOn && loOn));

  // R5: enables move only with a valid output
  a_r5_rotate_with_output: assert property (@(posedge clk) disable iff (rst)
    !$stable(enVec) |-> outValid);

  // R6: rotation keeps three lanes enabled
  a_r6_three_enabled: assert property (@(posedge clk) disable iff (rst)
    $countones(enVec) == 3);
endmodule

bind ringvote_top ringvote_checker u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid),
  .outCode(outCode), .enVec(ctrlBus.enables)
);

// File: tb/ringvote_top_bench.sv
module ringvote_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0, opB = '0, sabWord = '0;
  logic        injectEn = 1'b0;
  logic        outValid;
  logic [31:0] outResult;
  logic [5:0]  outCode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ringvote_top u_ringvote_top (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .sabWord(sabWord), .injectEn(injectEn), .outValid(outValid),
    .outResult(outResult), .outCode(outCode)
  );

  // model state (R6 reset values)
  logic [4:0] mEn = 5'b00111;
  logic [5:0] mPrev = {3'd5, 3'd5};

  // pipeline of expectations
  bit pbV = 0, paV = 0;
  logic [31:0] pbR, paR;
  logic [5:0]  pbC, paC;
  string pbT = "", paT = "";

  function automatic logic [31:0] laneVal(int k, logic [15:0] a, logic [15:0] b,
                                          logic [15:0] s, logic inj);
    logic [31:0] p;
    logic [15:0] m;
    p = 32'(a) * 32'(b);
    m = inj ? (s & (16'd1 << (5 - k))) : 16'd0;
    return p + 32'(m);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [15:0] b, input logic [15:0] s,
                      input logic inj, input logic v, input string tag);
    logic [31:0] r [1:5];
    logic [31:0] er;
    logic [5:0]  ec;
    bit found;
    @(negedge clk);
    if (pbV) begin
      check({pbT, " R8 valid"}, 32'(outValid), 32'd1);
      check({pbT, " R1/R2/R4 result"}, outResult, pbR);
      check({pbT, " R2/R3 code"}, 32'(outCode), 32'(pbC));
    end else begin
      check("R8 idle valid", 32'(outValid), 32'd0);
    end
    pbV = paV; pbR = paR; pbC = paC; pbT = paT;
    paV = v; paT = tag;
    if (v) begin
      for (int k = 1; k <= 5; k++) r[k] = laneVal(k, a, b, s, inj);
      found = 0; er = r[5]; ec = {3'd5, 3'd5};
      for (int k = 1; k <= 5; k++) begin
        int q;
        q = (k % 5) + 1;
        if (!found && mEn[k-1] && mEn[q-1] && r[k] == r[q]) begin
          found = 1; er = r[k]; ec = {3'(k), 3'(q)};
        end
      end
      if (ec != mPrev) mEn = {mEn[3:0], mEn[4]};
      mPrev = ec;
      paR = er; paC = ec;
    end
    inValid = v; opA = a; opB = b; sabWord = s; injectEn = inj;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R6 reset valid", 32'(outValid), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    // R6/R7: initial enables 1,2,3, no injection -> code 12, result A*B
    step(16'd3, 16'd5, 16'h001F, 1'b0, 1'b1, "R6 R7 first");
    // R5: previous code 55 vs 12 rotated -> lanes 2,3,4 -> 23
    step(16'd3, 16'd5, 16'h0000, 1'b0, 1'b1, "R5 R7 after rotate");
    step(16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 1'b1, "R5 R7 max operands");
    // R8: idle sample must not rotate
    step(16'd0, 16'd0, 16'h0000, 1'b0, 1'b0, "R8 idle");
    // R4: all lanes disagree -> lane 5 and code 55
    step(16'd7, 16'd9, 16'h001F, 1'b1, 1'b1, "R4 no match");
    // R1: only lane 1 disturbed
    step(16'd100, 16'd200, 16'h0010, 1'b1, 1'b1, "R1 lane1 bit");
    step(16'hFFFF, 16'hFFFF, 16'h001E, 1'b1, 1'b1, "R1 R4 wrap");
    for (int i = 0; i < 400; i++) begin
      logic [15:0] pat;
      pat = 16'($urandom) & 16'($urandom_range(0, 31));
      step(16'($urandom), 16'($urandom), pat | (16'($urandom) & 16'hFFE0),
           1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 9) != 0), "R2 R5 random");
    end
    step(16'd0, 16'd0, 16'd0, 1'b0, 1'b0, "R8 drain");
    step(16'd0, 16'd0, 16'd0, 1'b0, 1'b0, "R8 drain");
    step(16'd0, 16'd0, 16'd0, 1'b0, 1'b0, "R8 drain");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule